// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the control register that sits in front of a flash array's program and erase machinery. It holds three control bits. An arm bit opens the capture latches. A mode bit chooses between programming and erasing. A drive bit switches on the high programming voltage. While the block is armed, the first write on the array bus that lands inside the valid array window is copied into an address latch and a data latch. Those latches feed the array's programming logic. For an erase the captured address may be any location inside the window.

The register does not let software drive the bits freely. The drive bit can only be raised once a capture has taken place. While the drive bit is high, the arm and mode bits are frozen. Writes that break these rules are dropped quietly: the affected bits keep their old value and read back unchanged. The array and the voltage pump are outside this block.

Top module: `fpe_interlock`

## Requirements
- R1: A synchronous reset clears the arm, mode and drive bits and the capture flag.
- R2: With the arm bit set and no capture held, an array write whose address lies inside [ARR_LO, ARR_HI] loads its address and data into the latches and sets the capture flag on the following edge.
- R3: An array write whose address lies outside [ARR_LO, ARR_HI] never sets the capture flag and never changes the latches.
- R4: Once the capture flag is set, further array writes leave the latched address and data unchanged.
- R5: A register write that sets the drive bit (bit 2) takes effect only if three conditions hold: the arm bit is already set, a capture is held, and the same write keeps the arm bit (bit 0) set. Otherwise the drive bit reads back 0.
- R6: While the drive bit is set, a register write that clears the arm bit is ignored, and the arm bit stays 1.
- R7: While the drive bit is set, a register write that changes the mode bit (bit 1) is ignored.
- R8: While the drive bit is clear, register writes set the arm and mode bits to the written values. Mode 1 selects erase and mode 0 selects program, and the value appears on `erase_mode`.
- R9: Clearing the arm bit while the drive bit is clear also clears the capture flag. After that, arming again allows a new capture.
- R10: Writing the drive bit to 0 always clears it, whatever the other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Write data: bit0 arm, bit1 mode, bit2 drive |
| arr_wr | input | 1 | Array bus write strobe |
| arr_addr | input | AW | Array bus write address |
| arr_wdata | input | DW | Array bus write data |
| ctl_rdata | output | 3 | Register readback, same bit layout as write data |
| cap_valid | output | 1 | Capture flag |
| lat_addr | output | AW | Latched programming address |
| lat_data | output | DW | Latched programming data |
| erase_mode | output | 1 | Mode bit: 1 erase, 0 program |
| hv_en | output | 1 | High-voltage enable to the pump |

## Verification
A wrong internal state shows at the ports on the edge that follows the offending write. Every bit is a single register, so a wrongly accepted or wrongly dropped write shows up on `ctl_rdata` or `cap_valid` one cycle later. A latch that opens when it should not shows up on `lat_addr` or `lat_data` at that same edge. The bench covers every address of a small array together with every register write value from each reachable control state. A stale capture flag or a leaky freeze is therefore seen within two writes of its cause.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int ARM_BIT   = 0;
  localparam int MODE_BIT  = 1;
  localparam int DRIVE_BIT = 2;
  localparam int CTL_W     = 3;

  typedef struct packed {
    logic drive;
    logic mode;
    logic arm;
  } fpe_ctl_t;
endpackage

// File: rtl/fpe_range_decode.sv
module fpe_range_decode #(
  parameter int AW     = 16,
  parameter int ARR_LO = 16'h8000,
  parameter int ARR_HI = 16'hFFFF
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] LO = AW'(ARR_LO);
  localparam logic [AW-1:0] HI = AW'(ARR_HI);

  always_comb hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/fpe_ctl_reg.sv
module fpe_ctl_reg
  import fpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             cap_q,
  output fpe_ctl_t         ctl_q,
  output logic             arm_drop
);
  fpe_ctl_t ctl_d;
  logic     drive_ok;

  // the drive bit may rise only from a captured, armed state that stays armed
  always_comb drive_ok = ctl_q.arm && cap_q && wdata[ARM_BIT];

  always_comb begin
    ctl_d    = ctl_q;
    arm_drop = 1'b0;
    if (wr) begin
      if (ctl_q.drive) begin
        ctl_d.drive = wdata[DRIVE_BIT];
      end else begin
        ctl_d.arm   = wdata[ARM_BIT];
        ctl_d.mode  = wdata[MODE_BIT];
        ctl_d.drive = wdata[DRIVE_BIT] && drive_ok;
        arm_drop    = ctl_q.arm && !wdata[ARM_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

  assert_arm_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    ctl_q.drive |=> ctl_q.arm);
  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_q.drive |=> $stable(ctl_q.mode));
  assert_drive_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[DRIVE_BIT]) |=> !ctl_q.drive);
endmodule

// File: rtl/fpe_capture.sv
module fpe_capture #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          clear,
  input  logic          wr_hit,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          cap_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  logic take;

  always_comb take = armed && !cap_q && wr_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (clear) begin
      cap_q <= 1'b0;
    end else if (take) begin
      cap_q  <= 1'b1;
      addr_q <= addr;
      data_q <= data;
    end
  end

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    cap_q |=> ($stable(addr_q) && $stable(data_q)));
  assert_cap_needs_arm_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_q) |-> $past(armed && wr_hit));
endmodule

// File: rtl/fpe_interlock.sv
module fpe_interlock
  import fpe_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int ARR_LO = 16'h8000,
  parameter int ARR_HI = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             arr_wr,
  input  logic [AW-1:0]    arr_addr,
  input  logic [DW-1:0]    arr_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             cap_valid,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    lat_data,
  output logic             erase_mode,
  output logic             hv_en
);
  fpe_ctl_t ctl_q;
  logic     in_range;
  logic     arm_drop;
  logic     cap_q;

  fpe_range_decode #(.AW(AW), .ARR_LO(ARR_LO), .ARR_HI(ARR_HI)) dec_i (
    .addr (arr_addr),
    .hit  (in_range)
  );

  fpe_ctl_reg ctl_i (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .cap_q    (cap_q),
    .ctl_q    (ctl_q),
    .arm_drop (arm_drop)
  );

  fpe_capture #(.AW(AW), .DW(DW)) cap_i (
    .clk    (clk),
    .rst    (rst),
    .armed  (ctl_q.arm),
    .clear  (arm_drop),
    .wr_hit (arr_wr && in_range),
    .addr   (arr_addr),
    .data   (arr_wdata),
    .cap_q  (cap_q),
    .addr_q (lat_addr),
    .data_q (lat_data)
  );

  always_comb begin
    ctl_rdata  = ctl_q;
    cap_valid  = cap_q;
    erase_mode = ctl_q.mode;
    hv_en      = ctl_q.drive;
  end

  assert_drive_needs_capture_R5: assert property (@(posedge clk) disable iff (rst)
    hv_en |-> (ctl_q.arm && cap_q));
  assert_no_outside_capture_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_q) |-> $past(in_range));
  assert_disarm_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.arm) |-> !cap_q);
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (ctl_rdata == '0 && !cap_q));
endmodule

// File: tb/fpe_interlock_tb_top.sv
module fpe_interlock_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int LO = 8'h20;
  localparam int HI = 8'h9F;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 1'b0;
  logic [2:0]    ctl_wdata = '0;
  logic          arr_wr = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic [2:0]    ctl_rdata;
  logic          cap_valid;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic          erase_mode;
  logic          hv_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpe_interlock #(.AW(AW), .DW(DW), .ARR_LO(LO), .ARR_HI(HI)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .ctl_rdata(ctl_rdata), .cap_valid(cap_valid), .lat_addr(lat_addr),
    .lat_data(lat_data), .erase_mode(erase_mode), .hv_en(hv_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic ctl_write(input logic [2:0] w);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic arr_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
    @(negedge clk); arr_wr = 1'b0;
  endtask

  // requirement model: returns {drive, mode, arm, cap} after a register write
  function automatic logic [3:0] model(input logic l, input logic e, input logic h,
                                       input logic c, input logic [2:0] w);
    logic nl, ne, nh, nc;
    if (h) begin
      nh = w[2]; nl = 1'b1; ne = e; nc = c;
    end else begin
      nl = w[0]; ne = w[1];
      nh = w[2] & w[0] & l & c;
      nc = (l & ~w[0]) ? 1'b0 : c;
    end
    return {nh, ne, nl, nc};
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 ctl", ctl_rdata, 0);
    check("R1 cap", cap_valid, 0);

    // R2 / R3: sweep every address from an armed, empty state
    for (int a = 0; a < 256; a++) begin
      ctl_write(3'b000);
      ctl_write(3'b001);
      arr_write(a[7:0], a[7:0] ^ 8'h5A);
      if (a >= LO && a <= HI) begin
        check("R2 cap", cap_valid, 1);
        check("R2 addr", lat_addr, a);
        check("R2 data", lat_data, a ^ 8'h5A);
      end else begin
        check("R3 cap", cap_valid, 0);
      end
    end

    // R3: unarmed in-range write does not capture
    do_reset();
    arr_write(8'h40, 8'h11);
    check("R3 unarmed", cap_valid, 0);
    check("R3 unarmed addr", lat_addr, 0);

    // R4: second write leaves latches; R8 erase mode capture
    do_reset();
    ctl_write(3'b011);
    check("R8 erase", erase_mode, 1);
    arr_write(8'h55, 8'hC3);
    arr_write(8'h66, 8'h3C);
    check("R4 addr", lat_addr, 8'h55);
    check("R4 data", lat_data, 8'hC3);

    // R9: disarm clears capture, re-arm recaptures
    ctl_write(3'b000);
    check("R9 cap", cap_valid, 0);
    ctl_write(3'b001);
    arr_write(8'h77, 8'h99);
    check("R9 recapture", lat_addr, 8'h77);

    // drive raised then pump output
    ctl_write(3'b101);
    check("R5 hv", hv_en, 1);

    // state sweep: modes 0 off, 1 armed empty, 2 armed captured, 3 driving
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 8; w++) begin
          logic l, h, c;
          do_reset();
          l = (m != 0); c = (m >= 2); h = (m == 3);
          ctl_write({1'b0, e[0], l});
          if (c) arr_write(8'h30, 8'hA5);
          if (h) ctl_write({1'b1, e[0], 1'b1});
          exp = model(l, e[0], h, c, w[2:0]);
          ctl_write(w[2:0]);
          if (h) begin
            check("R6 arm", ctl_rdata[0], exp[1]);
            check("R7 mode", ctl_rdata[1], exp[2]);
            check("R10 drive", ctl_rdata[2], exp[3]);
          end else begin
            check("R5 drive", ctl_rdata[2], exp[3]);
            check("R8 bits", ctl_rdata[1:0], exp[2:1]);
          end
          check("R9 capflag", cap_valid, exp[0]);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule